// File: doc/BRIEF.md
# Double-Word Three-Way Comparator

This block works on two 32-bit operands, each supplied as a pair of 16-bit stack words. The right operand is the top pair of the stack and the left operand is the pair beneath it. From those four words it can do one of four things: form a 32-bit sum, form a 32-bit difference, or reduce the pair to one three-way verdict word (-1, 0 or +1) that orders left against right. The verdict can treat the operands as signed long integers or as unsigned long cardinals.

A single adder chain does all four operations. The low halves are combined first, and their carry feeds the high halves. A signed compare is turned into an unsigned one by adding a half-scale bias to both high words. The verdict then comes from the final carry, together with an OR of the two difference halves.

The block also reports how many stack entries the operation consumes. The surrounding stack logic applies that count. A one-cycle start pulse launches an operation. The result and a done strobe appear on the next cycle, and the result registers hold their value until the next start.

Top module: `dw_compare`

## Requirements
- R1: While reset is asserted, and after it is released with no start, done is 0, and res_lo, res_hi and pop_cnt are all 0.
- R2: done is 1 in exactly the cycle after a cycle in which start is sampled high. It is 0 in every other cycle.
- R3: op = 2'b00 (add) gives {res_hi,res_lo} = {left_hi,left_lo} + {right_hi,right_lo} modulo 2^32. The carry out of the low half is added into the high half.
- R4: op = 2'b01 (subtract) gives {res_hi,res_lo} = {left_hi,left_lo} - {right_hi,right_lo} modulo 2^32. A borrow out of the low half takes one away from the high half.
- R5: op = 2'b11 (unsigned compare) gives res_lo = 16'hFFFF if left < right as unsigned 32-bit values, 16'h0000 if they are equal, and 16'h0001 otherwise. res_hi is 0.
- R6: op = 2'b10 (signed compare) gives the same three-way encoding as R5, with both operands read as two's-complement 32-bit values.
- R7: pop_cnt is 2 after an add or subtract and 3 after either compare.
- R8: A compare reports 0 only when both the high halves and the low halves are equal. A difference confined to one half still yields a nonzero verdict.
- R9: In a cycle with no start sampled, res_lo, res_hi and pop_cnt keep their previous values, whatever the operand and op inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse; operands and op are sampled with it |
| op | input | 2 | 00 add, 01 subtract, 10 signed compare, 11 unsigned compare |
| left_lo | input | 16 | Low word of the deeper (left) operand |
| left_hi | input | 16 | High word of the left operand |
| right_lo | input | 16 | Low word of the top (right) operand |
| right_hi | input | 16 | High word of the right operand |
| done | output | 1 | One-cycle strobe marking a fresh result |
| res_lo | output | 16 | Low result word, or the verdict word for a compare |
| res_hi | output | 16 | High result word; 0 for a compare |
| pop_cnt | output | 2 | Stack entries consumed by the last operation |

## Verification
The bench targets the carry and borrow that cross from the low half into the high half. A chain that drops them gives a high word off by one for cases such as 0x0000FFFF + 1 and 0x00010000 - 1. The most negative long integer is compared against the most positive one, and all-ones is compared against zero in both modes. A missing or misplaced high-word bias shows up there as a flipped verdict, or as identical signed and unsigned verdicts. Operands that differ only in the high half, or only in the low half, expose an equality test that looks at one half alone: such a design would report 0 where +1 or -1 is due. Operand and op changes with start low must leave the results untouched. That catches a design that keeps recomputing its outputs.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_SCMP = 2'b10,
        OP_UCMP = 2'b11
    } dwc_op_e;

    localparam int unsigned POP_ARITH = 2;
    localparam int unsigned POP_CMP   = 3;

endpackage

// File: rtl/dwc_bias.sv
// Adds a half-scale offset to a word when enabled, mapping two's-complement
// order onto unsigned order.
module dwc_bias #(
    parameter int unsigned W = 16
) (
    input  logic         en,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] word_out
);
    localparam logic [W-1:0] HALF_SCALE = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        word_out = en ? (word_in + HALF_SCALE) : word_in;
    end
endmodule

// File: rtl/dwc_chain.sv
// Ripple of NSEG word-wide adders; segment 0 is least significant.
module dwc_chain #(
    parameter int unsigned W    = 16,
    parameter int unsigned NSEG = 2
) (
    input  logic                 subtract,
    input  logic [NSEG-1:0][W-1:0] a_seg,
    input  logic [NSEG-1:0][W-1:0] b_seg,
    output logic [NSEG-1:0][W-1:0] s_seg,
    output logic [NSEG:0]          carry
);
    assign carry[0] = subtract;

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        logic [W-1:0] b_eff;
        logic [W:0]   wide_sum;

        always_comb begin
            b_eff    = subtract ? ~b_seg[i] : b_seg[i];
            wide_sum = {1'b0, a_seg[i]} + {1'b0, b_eff} + {{W{1'b0}}, carry[i]};
        end

        assign s_seg[i]   = wide_sum[W-1:0];
        assign carry[i+1] = wide_sum[W];
    end
endmodule

// File: rtl/dwc_verdict.sv
// Turns the difference halves and the final carry into -1 / 0 / +1.
module dwc_verdict #(
    parameter int unsigned W    = 16,
    parameter int unsigned NSEG = 2
) (
    input  logic [NSEG-1:0][W-1:0] diff_seg,
    input  logic                   carry_out,
    output logic [W-1:0]           verdict
);
    localparam logic [W-1:0] V_LESS  = {W{1'b1}};
    localparam logic [W-1:0] V_EQUAL = '0;
    localparam logic [W-1:0] V_MORE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] merged;

    always_comb begin
        merged = '0;
        for (int i = 0; i < NSEG; i++) begin
            merged = merged | diff_seg[i];
        end
        if (!carry_out) begin
            verdict = V_LESS;
        end else if (merged == '0) begin
            verdict = V_EQUAL;
        end else begin
            verdict = V_MORE;
        end
    end
endmodule

// File: rtl/dw_compare.sv
module dw_compare #(
    parameter int unsigned HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [HALF_W-1:0] left_lo,
    input  logic [HALF_W-1:0] left_hi,
    input  logic [HALF_W-1:0] right_lo,
    input  logic [HALF_W-1:0] right_hi,
    output logic              done,
    output logic [HALF_W-1:0] res_lo,
    output logic [HALF_W-1:0] res_hi,
    output logic [1:0]        pop_cnt
);
    import dwc_pkg::*;

    localparam int unsigned NSEG = 2;

    typedef struct packed {
        logic              done;
        logic [HALF_W-1:0] lo;
        logic [HALF_W-1:0] hi;
        logic [1:0]        pop;
    } dwc_state_t;

    dwc_op_e    op_sel;
    logic       is_cmp;
    logic       is_signed;
    logic       do_sub;

    logic [HALF_W-1:0] lhi_b;
    logic [HALF_W-1:0] rhi_b;

    logic [NSEG-1:0][HALF_W-1:0] a_seg;
    logic [NSEG-1:0][HALF_W-1:0] b_seg;
    logic [NSEG-1:0][HALF_W-1:0] s_seg;
    logic [NSEG:0]               carry;
    logic [HALF_W-1:0]           verdict;

    dwc_state_t state_d, state_q;

    always_comb begin
        op_sel    = dwc_op_e'(op);
        is_cmp    = (op_sel == OP_SCMP) || (op_sel == OP_UCMP);
        is_signed = (op_sel == OP_SCMP);
        do_sub    = (op_sel != OP_ADD);
    end

    dwc_bias #(.W(HALF_W)) u_bias_left (
        .en      (is_signed),
        .word_in (left_hi),
        .word_out(lhi_b)
    );

    dwc_bias #(.W(HALF_W)) u_bias_right (
        .en      (is_signed),
        .word_in (right_hi),
        .word_out(rhi_b)
    );

    assign a_seg = {lhi_b, left_lo};
    assign b_seg = {rhi_b, right_lo};

    dwc_chain #(.W(HALF_W), .NSEG(NSEG)) u_chain (
        .subtract(do_sub),
        .a_seg   (a_seg),
        .b_seg   (b_seg),
        .s_seg   (s_seg),
        .carry   (carry)
    );

    dwc_verdict #(.W(HALF_W), .NSEG(NSEG)) u_verdict (
        .diff_seg (s_seg),
        .carry_out(carry[NSEG]),
        .verdict  (verdict)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = start;
        if (start) begin
            if (is_cmp) begin
                state_d.lo  = verdict;
                state_d.hi  = '0;
                state_d.pop = 2'(POP_CMP);
            end else begin
                state_d.lo  = s_seg[0];
                state_d.hi  = s_seg[1];
                state_d.pop = 2'(POP_ARITH);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign done    = state_q.done;
    assign res_lo  = state_q.lo;
    assign res_hi  = state_q.hi;
    assign pop_cnt = state_q.pop;
endmodule

// File: rtl/dwc_checker.sv
module dwc_checker #(
    parameter int unsigned HALF_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        op,
    input logic [HALF_W-1:0] left_lo,
    input logic [HALF_W-1:0] left_hi,
    input logic [HALF_W-1:0] right_lo,
    input logic [HALF_W-1:0] right_hi,
    input logic              done,
    input logic [HALF_W-1:0] res_lo,
    input logic [HALF_W-1:0] res_hi,
    input logic [1:0]        pop_cnt
);
    localparam logic [HALF_W-1:0] ONE = {{(HALF_W-1){1'b0}}, 1'b1};

    assert_done_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    assert_add_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 2'b00) |=>
            {res_hi, res_lo} == $past({left_hi, left_lo}) + $past({right_hi, right_lo}));

    assert_sub_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 2'b01) |=>
            {res_hi, res_lo} == $past({left_hi, left_lo}) - $past({right_hi, right_lo}));

    assert_cmp_encoding_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op[1]) |=>
            (res_hi == '0) && (res_lo == '0 || res_lo == ONE || res_lo == '1));

    assert_equal_gives_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op[1] && {left_hi, left_lo} == {right_hi, right_lo}) |=> res_lo == '0);

    assert_pop_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> pop_cnt == ($past(op[1]) ? 2'd3 : 2'd2));

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(res_lo) && $stable(res_hi) && $stable(pop_cnt));

endmodule

bind dw_compare dwc_checker #(.HALF_W(HALF_W)) u_dwc_checker (.*);

// File: tb/tb_dw_compare.sv
`timescale 1ns/1ps
module tb_dw_compare;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [15:0] left_lo = '0, left_hi = '0, right_lo = '0, right_hi = '0;
    logic        done;
    logic [15:0] res_lo, res_hi;
    logic [1:0]  pop_cnt;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dw_compare dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .left_lo(left_lo), .left_hi(left_hi),
        .right_lo(right_lo), .right_hi(right_hi),
        .done(done), .res_lo(res_lo), .res_hi(res_hi), .pop_cnt(pop_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Launch one operation; returns after the result cycle, sampled mid-cycle.
    task automatic launch(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op = o;
        {left_hi, left_lo} = a;
        {right_hi, right_lo} = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    function automatic logic [15:0] verdict_u(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? 16'hFFFF : ((a == b) ? 16'h0000 : 16'h0001);
    endfunction

    function automatic logic [15:0] verdict_s(input logic [31:0] a, input logic [31:0] b);
        return ($signed(a) < $signed(b)) ? 16'hFFFF : ((a == b) ? 16'h0000 : 16'h0001);
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 result", {res_hi, res_lo}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pop", {30'd0, pop_cnt}, 32'd0);
        chk("R1 done after release", {31'd0, done}, 32'd0);
    endtask

    task automatic t_add(input logic [31:0] a, input logic [31:0] b);
        launch(2'b00, a, b);
        chk("R2 done", {31'd0, done}, 32'd1);
        chk("R3 sum", {res_hi, res_lo}, a + b);
        chk("R7 pop arith", {30'd0, pop_cnt}, 32'd2);
    endtask

    task automatic t_sub(input logic [31:0] a, input logic [31:0] b);
        launch(2'b01, a, b);
        chk("R4 difference", {res_hi, res_lo}, a - b);
        chk("R7 pop arith", {30'd0, pop_cnt}, 32'd2);
    endtask

    task automatic t_ucmp(input string req, input logic [31:0] a, input logic [31:0] b);
        launch(2'b11, a, b);
        chk(req, {res_hi, res_lo}, {16'd0, verdict_u(a, b)});
        chk("R7 pop cmp", {30'd0, pop_cnt}, 32'd3);
    endtask

    task automatic t_scmp(input string req, input logic [31:0] a, input logic [31:0] b);
        launch(2'b10, a, b);
        chk(req, {res_hi, res_lo}, {16'd0, verdict_s(a, b)});
        chk("R7 pop cmp", {30'd0, pop_cnt}, 32'd3);
    endtask

    task automatic t_hold();
        logic [31:0] kept;
        launch(2'b01, 32'h0001_0000, 32'h0000_0001);
        kept = {res_hi, res_lo};
        @(negedge clk);
        chk("R2 done drops", {31'd0, done}, 32'd0);
        op = 2'b00;
        {left_hi, left_lo} = 32'h1234_5678;
        {right_hi, right_lo} = 32'h1111_1111;
        repeat (2) @(negedge clk);
        chk("R9 result held", {res_hi, res_lo}, kept);
        chk("R9 pop held", {30'd0, pop_cnt}, 32'd2);
        chk("R2 no done while idle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_add(32'h0000_FFFF, 32'h0000_0001);
        t_add(32'hFFFF_FFFF, 32'h0000_0001);
        t_add(32'h1234_8000, 32'h4321_8000);
        t_sub(32'h0001_0000, 32'h0000_0001);
        t_sub(32'h0000_0000, 32'h0000_0001);
        t_sub(32'h5555_AAAA, 32'h1111_2222);
        t_ucmp("R5 all-ones vs zero", 32'hFFFF_FFFF, 32'h0000_0000);
        t_ucmp("R5 less", 32'h0000_0001, 32'h8000_0000);
        t_ucmp("R5 equal", 32'hABCD_1234, 32'hABCD_1234);
        t_scmp("R6 all-ones vs zero", 32'hFFFF_FFFF, 32'h0000_0000);
        t_scmp("R6 min vs max", 32'h8000_0000, 32'h7FFF_FFFF);
        t_scmp("R6 max vs min", 32'h7FFF_FFFF, 32'h8000_0000);
        t_scmp("R6 equal negative", 32'hFFFE_0001, 32'hFFFE_0001);
        t_ucmp("R8 high half only", 32'h0001_0000, 32'h0000_0000);
        t_ucmp("R8 low half only", 32'h0000_0001, 32'h0000_0000);
        t_scmp("R8 signed low half only", 32'hFFFF_0000, 32'hFFFF_0001);
        t_hold();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule